// File: doc/BRIEF.md
# Parallel Loop Thread Issue Unit

This block runs one parallel loop whose iterations are independent of one another. Each iteration becomes an implicit thread. At most `THREADS` of them (16 by default) are live at one time, and longer loops run in successive batches. Within a batch the unit walks the loop body one position at a time. At each position it issues that instruction once for every live thread, in rising thread order, before it moves to the next position. Every instruction that reaches a queue behind the unit has been issued back to back by all threads, so the latency of each stage is hidden.

Software first fills a small body memory with encoded instructions. It then pulses `start` together with an iteration count and a body length. Each issued instruction carries the following:

- the thread id;
- a register address built from the thread id and the instruction's register select;
- a tile address equal to the instruction's base plus its stride times the iteration index.

The instruction goes to one of three ready/valid queues, chosen by its class field: device memory transfers, cache load/store, or arithmetic. When the last instruction of the last iteration has been accepted, the unit pulses `done` for one cycle.

Top module: `loop_thread_issue`

## Requirements
- R1: After reset, `busy`, `done` and all three queue valids are low.
- R2: Within a batch the issue order is position-major and thread-minor. Every live thread issues body position p, in thread order 0,1,2,…, before any thread issues position p+1.
- R3: Iterations are split into batches of at most `THREADS` threads. Batch k covers iterations k·`THREADS` onward. Thread t of a batch runs iteration (batch start + t). A short final batch rotates only over its live threads.
- R4: `iss_addr` equals (base + stride × iteration index) modulo 2^13. Base is instruction bits [25:13] and stride is bits [12:0].
- R5: `iss_tid` is the thread id, and `iss_reg` is {thread id, register select}, where the register select is instruction bits [27:26].
- R6: The class field, instruction bits [29:28], routes each instruction. 00 goes to `mem_valid`, 01 goes to `cache_valid`, and 10 or 11 go to `arith_valid`. At most one valid is high at a time.
- R7: While the selected queue holds its ready low, the valid and the whole payload stay unchanged.
- R8: `done` is high for exactly one cycle, in the cycle after the final handshake, and `busy` is low from that cycle on.
- R9: A start with zero iterations or zero body length issues nothing. It raises `done` in the next cycle.
- R10: A `start` pulse while `busy` is high is ignored, and the running loop's issue stream is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prog_we | input | 1 | Body memory write enable |
| prog_addr | input | 4 | Body memory write position |
| prog_data | input | 30 | Encoded instruction {class, reg select, base, stride} |
| start | input | 1 | Launch a loop (ignored while busy) |
| iter_count | input | 16 | Number of loop iterations |
| body_len | input | 5 | Body length in instructions (0..16) |
| busy | output | 1 | A loop is being issued |
| done | output | 1 | One-cycle completion pulse |
| mem_valid | output | 1 | Issue to device memory queue |
| mem_ready | input | 1 | Device memory queue accepts |
| cache_valid | output | 1 | Issue to cache load/store queue |
| cache_ready | input | 1 | Cache queue accepts |
| arith_valid | output | 1 | Issue to arithmetic queue |
| arith_ready | input | 1 | Arithmetic queue accepts |
| iss_tid | output | 4 | Thread id of the issued instruction |
| iss_reg | output | 6 | Thread-qualified register address |
| iss_addr | output | 13 | Computed tile address |

## Verification
The assertions assume three things about the inputs:

- The body memory is not written while `busy` is high.
- `body_len` never exceeds the body depth.
- Every queue eventually raises ready.

The stall-stability property depends on the first of these. The stimulus loads the body memory only while the unit is idle. It uses lengths from 0 to 16 and drives the ready inputs from a free-running pseudo-random sequence, so every stalled queue is released within a few cycles.

// File: rtl/lti_pkg.sv
package lti_pkg;
   localparam int TILE_AW = 13;

   typedef enum logic [1:0] {
      CLS_MEM    = 2'b00,
      CLS_CACHE  = 2'b01,
      CLS_ARITH  = 2'b10,
      CLS_ARITHX = 2'b11
   } cls_e;

   typedef struct packed {
      cls_e               cls;
      logic [1:0]         sel;
      logic [TILE_AW-1:0] base;
      logic [TILE_AW-1:0] stride;
   } instr_t;

   localparam int INSTR_W = $bits(instr_t);
endpackage

// File: rtl/lti_sequencer.sv
module lti_sequencer #(
   parameter int THREADS    = 16,
   parameter int BODY_DEPTH = 16,
   parameter int ITER_W     = 16,
   localparam int TID_W  = $clog2(THREADS),
   localparam int POS_W  = $clog2(BODY_DEPTH),
   localparam int LEN_W  = POS_W + 1,
   localparam int LIVE_W = TID_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ITER_W-1:0] iter_count,
   input  logic [LEN_W-1:0]  body_len,
   input  logic              fire,
   output logic              busy,
   output logic              done,
   output logic [TID_W-1:0]  tid,
   output logic [POS_W-1:0]  pos,
   output logic [ITER_W-1:0] iter_idx
);
   localparam logic [ITER_W:0]  THR_X = (ITER_W+1)'(THREADS);
   localparam logic [LIVE_W-1:0] THR_L = LIVE_W'(THREADS);
   localparam logic [LEN_W-1:0] DEP_L = LEN_W'(BODY_DEPTH);

   logic              busy_q, done_q;
   logic [ITER_W-1:0] base_q, total_q;
   logic [LIVE_W-1:0] live_q;
   logic [LEN_W-1:0]  len_q;
   logic [TID_W-1:0]  tid_q;
   logic [POS_W-1:0]  pos_q;

   logic [ITER_W:0]   next_base, rem;
   logic [LIVE_W-1:0] next_live, first_live;
   logic              last_tid, last_pos;

   always_comb begin
      next_base  = {1'b0, base_q} + (ITER_W+1)'(live_q);
      rem        = {1'b0, total_q} - next_base;
      next_live  = (rem >= THR_X) ? THR_L : rem[LIVE_W-1:0];
      first_live = ({1'b0, iter_count} >= THR_X) ? THR_L : iter_count[LIVE_W-1:0];
      last_tid   = ({1'b0, tid_q} == live_q - 1'b1);
      last_pos   = ({1'b0, pos_q} == len_q - 1'b1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0; done_q <= 1'b0;
         base_q <= '0; total_q <= '0; live_q <= '0;
         len_q <= '0; tid_q <= '0; pos_q <= '0;
      end else begin
         done_q <= 1'b0;
         if (!busy_q) begin
            if (start) begin
               if (iter_count == '0 || body_len == '0) begin
                  done_q <= 1'b1;
               end else begin
                  busy_q  <= 1'b1;
                  base_q  <= '0;
                  total_q <= iter_count;
                  live_q  <= first_live;
                  len_q   <= (body_len > DEP_L) ? DEP_L : body_len;
                  tid_q   <= '0;
                  pos_q   <= '0;
               end
            end
         end else if (fire) begin
            if (!last_tid) begin
               tid_q <= tid_q + 1'b1;
            end else begin
               tid_q <= '0;
               if (!last_pos) begin
                  pos_q <= pos_q + 1'b1;
               end else begin
                  pos_q <= '0;
                  if (rem == '0) begin
                     busy_q <= 1'b0;
                     done_q <= 1'b1;
                  end else begin
                     base_q <= next_base[ITER_W-1:0];
                     live_q <= next_live;
                  end
               end
            end
         end
      end
   end

   assign busy     = busy_q;
   assign done     = done_q;
   assign tid      = tid_q;
   assign pos      = pos_q;
   assign iter_idx = base_q + ITER_W'(tid_q);

   // R3: the rotating thread never leaves the live set of its batch
   a_r3_tid_in_batch: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> ({1'b0, tid_q} < live_q));
   // R3: a batch is never empty and never exceeds the thread limit
   a_r3_batch_cap: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> (live_q != '0 && live_q <= THR_L));
   // R9: an empty loop completes on the next cycle without going busy
   a_r9_empty_loop: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy_q && iter_count == '0) |=> (done_q && !busy_q));
endmodule

// File: rtl/lti_addr_gen.sv
module lti_addr_gen #(
   parameter int ITER_W = 16,
   parameter int AW     = lti_pkg::TILE_AW
) (
   input  logic [AW-1:0]     base,
   input  logic [AW-1:0]     stride,
   input  logic [ITER_W-1:0] iter_idx,
   output logic [AW-1:0]     addr
);
   logic [AW-1:0] it, prod;

   generate
      if (ITER_W >= AW) begin : g_slice
         assign it = iter_idx[AW-1:0];
      end else begin : g_extend
         assign it = {{(AW-ITER_W){1'b0}}, iter_idx};
      end
   endgenerate

   assign prod = stride * it;
   assign addr = base + prod;
endmodule

// File: rtl/lti_router.sv
module lti_router (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            valid_in,
   input  lti_pkg::cls_e   cls,
   input  logic            mem_ready,
   input  logic            cache_ready,
   input  logic            arith_ready,
   output logic            mem_valid,
   output logic            cache_valid,
   output logic            arith_valid,
   output logic            ready_out
);
   import lti_pkg::*;

   always_comb begin
      mem_valid = 1'b0; cache_valid = 1'b0; arith_valid = 1'b0; ready_out = 1'b0;
      unique case (cls)
         CLS_MEM:   begin mem_valid   = valid_in; ready_out = mem_ready;   end
         CLS_CACHE: begin cache_valid = valid_in; ready_out = cache_ready; end
         default:   begin arith_valid = valid_in; ready_out = arith_ready; end
      endcase
   end

   // R6: one destination queue at a time
   a_r6_one_queue: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({mem_valid, cache_valid, arith_valid}));
endmodule

// File: rtl/loop_thread_issue.sv
module loop_thread_issue #(
   parameter int THREADS    = 16,
   parameter int BODY_DEPTH = 16,
   parameter int ITER_W     = 16,
   localparam int TID_W = $clog2(THREADS),
   localparam int POS_W = $clog2(BODY_DEPTH),
   localparam int LEN_W = POS_W + 1,
   localparam int AW    = lti_pkg::TILE_AW,
   localparam int IW    = lti_pkg::INSTR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              prog_we,
   input  logic [POS_W-1:0]  prog_addr,
   input  logic [IW-1:0]     prog_data,
   input  logic              start,
   input  logic [ITER_W-1:0] iter_count,
   input  logic [LEN_W-1:0]  body_len,
   output logic              busy,
   output logic              done,
   output logic              mem_valid,
   input  logic              mem_ready,
   output logic              cache_valid,
   input  logic              cache_ready,
   output logic              arith_valid,
   input  logic              arith_ready,
   output logic [TID_W-1:0]  iss_tid,
   output logic [TID_W+1:0]  iss_reg,
   output logic [AW-1:0]     iss_addr
);
   import lti_pkg::*;

   generate
      if (THREADS < 2 || (1 << TID_W) != THREADS) begin : g_bad_threads
         $error("THREADS must be a power of two of at least 2");
      end
      if (BODY_DEPTH < 2 || (1 << POS_W) != BODY_DEPTH) begin : g_bad_depth
         $error("BODY_DEPTH must be a power of two of at least 2");
      end
      if (ITER_W <= TID_W) begin : g_bad_iter
         $error("ITER_W must exceed the thread id width");
      end
   endgenerate

   instr_t            body_mem [BODY_DEPTH];
   instr_t            cur;
   logic [TID_W-1:0]  tid;
   logic [POS_W-1:0]  pos;
   logic [ITER_W-1:0] iter_idx;
   logic              ready_sel, fire;

   always_ff @(posedge clk) begin
      if (prog_we) body_mem[prog_addr] <= instr_t'(prog_data);
   end

   assign cur  = body_mem[pos];
   assign fire = busy && ready_sel;

   lti_sequencer #(.THREADS(THREADS), .BODY_DEPTH(BODY_DEPTH), .ITER_W(ITER_W)) i_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .iter_count(iter_count),
      .body_len(body_len), .fire(fire), .busy(busy), .done(done),
      .tid(tid), .pos(pos), .iter_idx(iter_idx));

   lti_addr_gen #(.ITER_W(ITER_W), .AW(AW)) i_agen (
      .base(cur.base), .stride(cur.stride), .iter_idx(iter_idx), .addr(iss_addr));

   lti_router i_route (
      .clk(clk), .rst_n(rst_n), .valid_in(busy), .cls(cur.cls),
      .mem_ready(mem_ready), .cache_ready(cache_ready), .arith_ready(arith_ready),
      .mem_valid(mem_valid), .cache_valid(cache_valid), .arith_valid(arith_valid),
      .ready_out(ready_sel));

   assign iss_tid = tid;
   assign iss_reg = {tid, cur.sel};

   // R7: a refused offer is held unchanged into the next cycle
   a_r7_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !ready_sel) |=> (busy && $stable(iss_addr) && $stable(iss_reg)
                                && $stable({mem_valid, cache_valid, arith_valid})));
   // R8: completion is a single-cycle pulse
   a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R8: completion coincides with the unit going idle
   a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
endmodule

// File: tb/test_loop_thread_issue.sv
module test_loop_thread_issue;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic prog_we = 1'b0;
   logic [3:0] prog_addr = '0;
   logic [29:0] prog_data = '0;
   logic start = 1'b0;
   logic [15:0] iter_count = '0;
   logic [4:0] body_len = '0;
   logic busy, done, mem_valid, cache_valid, arith_valid;
   logic mem_ready = 1'b0, cache_ready = 1'b0, arith_ready = 1'b0;
   logic [3:0] iss_tid;
   logic [5:0] iss_reg;
   logic [12:0] iss_addr;

   int checks = 0;
   int fails = 0;
   logic [15:0] lfsr = 16'hACE1;

   always #4 clk = ~clk;

   loop_thread_issue i_loop_thread_issue (
      .clk(clk), .rst_n(rst_n), .prog_we(prog_we), .prog_addr(prog_addr),
      .prog_data(prog_data), .start(start), .iter_count(iter_count),
      .body_len(body_len), .busy(busy), .done(done),
      .mem_valid(mem_valid), .mem_ready(mem_ready),
      .cache_valid(cache_valid), .cache_ready(cache_ready),
      .arith_valid(arith_valid), .arith_ready(arith_ready),
      .iss_tid(iss_tid), .iss_reg(iss_reg), .iss_addr(iss_addr));

   // {iterations[15:0], body length[4:0], inject start[1], random ready[0]}
   localparam logic [22:0] VEC [7] = '{
      {16'd2,  5'd4,  2'b00},
      {16'd16, 5'd3,  2'b01},
      {16'd17, 5'd2,  2'b01},
      {16'd35, 5'd5,  2'b01},
      {16'd1,  5'd1,  2'b00},
      {16'd40, 5'd16, 2'b11},
      {16'd33, 5'd7,  2'b10}
   };

   function automatic logic [29:0] body_word(input int i);
      logic [1:0] c, s;
      logic [12:0] b, st;
      c  = 2'(i % 4);
      s  = 2'((i * 3) % 4);
      b  = 13'((i * 523 + 11) % 8192);
      st = (i == 15) ? 13'h1FFF : 13'(i * 37 + 1);
      return {c, s, b, st};
   endfunction

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, got, exp);
      end
   endtask

   task automatic run_loop(input int iters, input int blen, input bit rnd, input bit inject);
      int item = 0;
      @(negedge clk);
      iter_count = 16'(iters); body_len = 5'(blen); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int b = 0; b < iters; b += 16) begin
         int live = (iters - b >= 16) ? 16 : iters - b;
         for (int p = 0; p < blen; p++) begin
            for (int t = 0; t < live; t++) begin
               logic [29:0] w = body_word(p);
               logic [2:0] exp_v;
               logic [12:0] exp_a;
               bit hs = 1'b0;
               int idx = b + t;
               exp_v = (w[29:28] == 2'b00) ? 3'b001 : (w[29:28] == 2'b01) ? 3'b010 : 3'b100;
               exp_a = 13'(w[25:13] + 13'(w[12:0] * 13'(idx)));
               do begin
                  start = 1'b0;
                  if (inject && item == 2) begin
                     start = 1'b1; iter_count = 16'd3; // R10: must be ignored
                  end
                  lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                  mem_ready   = rnd ? lfsr[0] : 1'b1;
                  cache_ready = rnd ? lfsr[3] : 1'b1;
                  arith_ready = rnd ? lfsr[7] : 1'b1;
                  #1;
                  // R2 and R3 ordering: each sample must match the expected item
                  chk("R6 routing (R2/R3 order)", {29'd0, arith_valid, cache_valid, mem_valid}, {29'd0, exp_v});
                  chk("R5 tid/reg (R10 stream)", {22'd0, iss_tid, iss_reg}, {22'd0, 4'(t), 4'(t), w[27:26]});
                  chk("R4 address (R7 held on stall)", {19'd0, iss_addr}, {19'd0, exp_a});
                  hs = (exp_v[0] && mem_ready) || (exp_v[1] && cache_ready) || (exp_v[2] && arith_ready);
                  @(negedge clk);
                  start = 1'b0;
                  iter_count = 16'(iters);
               end while (!hs);
               item++;
            end
         end
      end
      mem_ready = 1'b0; cache_ready = 1'b0; arith_ready = 1'b0;
      #1;
      chk("R8 done after last handshake", {30'd0, done, busy}, 32'd2);
      @(negedge clk);
      #1;
      chk("R8 done single cycle", {29'd0, done, busy, mem_valid | cache_valid | arith_valid}, 32'd0);
   endtask

   task automatic run_empty(input int iters, input int blen);
      @(negedge clk);
      iter_count = 16'(iters); body_len = 5'(blen); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      #1;
      chk("R9 empty loop done", {28'd0, done, busy, mem_valid | cache_valid, arith_valid}, 32'h8);
      @(negedge clk);
      #1;
      chk("R9 empty loop quiet", {28'd0, done, busy, mem_valid | cache_valid, arith_valid}, 32'h0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      #1;
      chk("R1 reset state", {27'd0, busy, done, mem_valid, cache_valid, arith_valid}, 32'd0);
      rst_n = 1'b1;
      for (int i = 0; i < 16; i++) begin
         @(negedge clk);
         prog_we = 1'b1; prog_addr = 4'(i); prog_data = body_word(i);
      end
      @(negedge clk);
      prog_we = 1'b0;
      #1;
      chk("R1 idle after programming", {27'd0, busy, done, mem_valid, cache_valid, arith_valid}, 32'd0);
      for (int v = 0; v < 7; v++) begin
         run_loop(int'(VEC[v][22:7]), int'(VEC[v][6:2]), VEC[v][0], VEC[v][1]);
      end
      run_empty(0, 3);
      run_empty(5, 0);
      run_loop(3, 2, 1'b1, 1'b0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule